// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block predicts where instruction fetch goes next. It is a tagged cache with several ways per set. Every cycle the fetch stage presents its current address. The block compares that address against the stored branch addresses of one set in the same cycle, and it returns the next fetch address without any register on the path. Each entry holds a tag, a 2-bit saturating outcome counter and a word-aligned target. A matching entry alone does not redirect fetch. The stored target replaces the sequential address only when the counter of the matching entry leans toward taken.

When a branch resolves in execute, an update port presents its address, its outcome and its target. If the branch already has an entry, the port refreshes that entry. Otherwise it installs a new one, taking an empty way first and else the way picked by tree pseudo-LRU state kept for each set. The new contents become visible from the cycle after the update. A lookup in the same cycle as an update always reads the contents from before the update.

Top module: `btb_top`

## Requirements
- R1: When the lookup finds no matching entry, lookup_hit_o is 0, pred_taken_o is 0 and next_pc_o equals fetch_pc_i + 4.
- R2: A lookup hits only when a valid way of the set chosen by address bits [8:2] holds a tag equal to address bits [31:9]. Bits [1:0] take no part in the match, and at most one way matches.
- R3: On a hit whose counter has bit 1 clear (value 0 or 1), lookup_hit_o is 1, pred_taken_o is 0 and next_pc_o equals fetch_pc_i + 4.
- R4: On a hit whose counter has bit 1 set (value 2 or 3), pred_taken_o is 1 and next_pc_o equals the stored target: bits [31:2] of the last target written, with bits [1:0] zero.
- R5: An update that misses installs an entry with the update address's tag and target. The counter starts at 2 if the branch was taken and at 1 if it was not.
- R6: An update that hits moves the counter up by one on taken and down by one on not-taken, holding at 3 and at 0. It replaces the stored target only when the branch was taken.
- R7: An installing update takes the lowest-numbered invalid way of the set. If all ways are valid, it takes the way picked by the set's 3-bit tree: bit 0 chooses the half (0: ways 0-1, 1: ways 2-3), bit 1 chooses between ways 0 and 1, and bit 2 chooses between ways 2 and 3 (0 picks the lower way). Every update, whether it installs or hits, sets the bits on the written way's path to point away from that way. Lookups leave the tree unchanged.
- R8: A lookup in the same cycle as an update reads the contents from before that update. The update takes effect for lookups from the next cycle on.
- R9: Reset clears every valid bit and every tree, so all lookups miss until entries are installed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc_i | input | 32 | Current fetch address |
| lookup_hit_o | output | 1 | Fetch address matches a valid entry |
| pred_taken_o | output | 1 | Matching entry predicts taken |
| next_pc_o | output | 32 | Predicted next fetch address |
| upd_valid_i | input | 1 | Resolved branch update this cycle |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| upd_target_i | input | 32 | Resolved target address |

## Verification
The fetch lookup and the resolve-time update can fall in the same cycle. They may touch the same set or even the same entry. The bench provokes this on purpose. It installs a branch while fetching that branch's own address, and it raises a counter across the taken threshold while the same entry is being looked up. A long random phase then mixes updates and lookups over a few sets and a handful of tags. The scoreboard works out each expected lookup from a model state that has not yet taken in that cycle's update, so any result showing the new contents a cycle too early is reported as a mismatch.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int ADDR_W = 32;
    localparam int SETS   = 128;
    localparam int WAYS   = 4;
    localparam int HIST_W = 2;

    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - 2 - IDX_W;
    localparam int TGT_W  = ADDR_W - 2;
    localparam int LRU_W  = WAYS - 1;
    localparam int LEVELS = WAY_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [HIST_W-1:0] hist_t;
    typedef logic [LRU_W-1:0]  lru_t;

    typedef struct packed {
        tag_t              tag;
        hist_t             hist;
        logic [TGT_W-1:0]  target;
    } entry_t;

    function automatic idx_t addr_idx(input addr_t a);
        return a[IDX_W+1:2];
    endfunction

    function automatic tag_t addr_tag(input addr_t a);
        return a[ADDR_W-1:IDX_W+2];
    endfunction

    function automatic logic hist_taken(input hist_t h);
        return h[HIST_W-1];
    endfunction

    function automatic hist_t hist_init(input logic taken);
        hist_t weak_t;
        weak_t = hist_t'(1) << (HIST_W - 1);
        return taken ? weak_t : weak_t - hist_t'(1);
    endfunction

    function automatic hist_t hist_step(input hist_t h, input logic taken);
        if (taken && (h != '1))
            return h + hist_t'(1);
        else if (!taken && (h != '0))
            return h - hist_t'(1);
        else
            return h;
    endfunction

    function automatic way_t tree_victim(input lru_t b);
        way_t w;
        int   node;
        w    = '0;
        node = 0;
        for (int l = 0; l < LEVELS; l++) begin
            w    = way_t'(w << 1) | way_t'(b[node]);
            node = 2 * node + 1 + int'(b[node]);
        end
        return w;
    endfunction

    function automatic lru_t tree_touch(input lru_t b, input way_t w);
        lru_t r;
        int   node;
        logic d;
        r    = b;
        node = 0;
        for (int l = 0; l < LEVELS; l++) begin
            d       = w[WAY_W-1-l];
            r[node] = ~d;
            node    = 2 * node + 1 + int'(d);
        end
        return r;
    endfunction

endpackage

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
(
    input  entry_t           ways_i [WAYS],
    input  logic [WAYS-1:0]  valid_i,
    input  tag_t             tag_i,
    output logic [WAYS-1:0]  hit_vec_o,
    output logic             hit_o,
    output way_t             way_o,
    output entry_t           entry_o
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec_o[w] = valid_i[w] && (ways_i[w].tag == tag_i);
    end

    assign hit_o = |hit_vec_o;

    always_comb begin
        way_o   = '0;
        entry_o = ways_i[0];
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec_o[w]) begin
                way_o   = way_t'(w);
                entry_o = ways_i[w];
            end
        end
    end

endmodule

// File: rtl/btb_plru.sv
module btb_plru
    import btb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  idx_t             set_i,
    input  logic [WAYS-1:0]  valid_i,
    input  logic             touch_en_i,
    input  way_t             touch_way_i,
    output way_t             repl_way_o
);

    lru_t tree_q [SETS];

    logic found_free;
    way_t free_way;

    always_comb begin
        found_free = 1'b0;
        free_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                found_free = 1'b1;
                free_way   = way_t'(w);
            end
        end
    end

    assign repl_way_o = found_free ? free_way : tree_victim(tree_q[set_i]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                tree_q[s] <= '0;
        end else if (touch_en_i) begin
            tree_q[set_i] <= tree_touch(tree_q[set_i], touch_way_i);
        end
    end

endmodule

// File: rtl/btb_top.sv
module btb_top
    import btb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  fetch_pc_i,
    output logic               lookup_hit_o,
    output logic               pred_taken_o,
    output logic [ADDR_W-1:0]  next_pc_o,
    input  logic               upd_valid_i,
    input  logic [ADDR_W-1:0]  upd_pc_i,
    input  logic               upd_taken_i,
    input  logic [ADDR_W-1:0]  upd_target_i
);

    entry_t          data_q  [SETS][WAYS];
    logic [WAYS-1:0] valid_q [SETS];

    // fetch side
    idx_t            f_idx;
    entry_t          f_set [WAYS];
    logic [WAYS-1:0] f_hit_vec;
    logic            f_hit;
    way_t            f_way;
    entry_t          f_entry;

    // update side
    idx_t            u_idx;
    entry_t          u_set [WAYS];
    logic [WAYS-1:0] u_hit_vec;
    logic            u_hit;
    way_t            u_way;
    entry_t          u_entry;
    way_t            repl_way;
    way_t            wr_way;
    entry_t          wr_entry;

    logic            unused_low_bits;
    assign unused_low_bits = ^{upd_pc_i[1:0], upd_target_i[1:0], f_way, u_hit_vec};

    assign f_idx = addr_idx(fetch_pc_i);
    assign u_idx = addr_idx(upd_pc_i);

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            f_set[w] = data_q[f_idx][w];
            u_set[w] = data_q[u_idx][w];
        end
    end

    btb_lookup u_fetch_cmp (
        .ways_i    (f_set),
        .valid_i   (valid_q[f_idx]),
        .tag_i     (addr_tag(fetch_pc_i)),
        .hit_vec_o (f_hit_vec),
        .hit_o     (f_hit),
        .way_o     (f_way),
        .entry_o   (f_entry)
    );

    btb_lookup u_upd_cmp (
        .ways_i    (u_set),
        .valid_i   (valid_q[u_idx]),
        .tag_i     (addr_tag(upd_pc_i)),
        .hit_vec_o (u_hit_vec),
        .hit_o     (u_hit),
        .way_o     (u_way),
        .entry_o   (u_entry)
    );

    btb_plru u_repl (
        .clk         (clk),
        .rst         (rst),
        .set_i       (u_idx),
        .valid_i     (valid_q[u_idx]),
        .touch_en_i  (upd_valid_i),
        .touch_way_i (wr_way),
        .repl_way_o  (repl_way)
    );

    assign wr_way = u_hit ? u_way : repl_way;

    always_comb begin
        wr_entry.tag = addr_tag(upd_pc_i);
        if (u_hit) begin
            wr_entry.hist   = hist_step(u_entry.hist, upd_taken_i);
            wr_entry.target = upd_taken_i ? upd_target_i[ADDR_W-1:2] : u_entry.target;
        end else begin
            wr_entry.hist   = hist_init(upd_taken_i);
            wr_entry.target = upd_target_i[ADDR_W-1:2];
        end
    end

    always_ff @(posedge clk) begin
        if (upd_valid_i)
            data_q[u_idx][wr_way] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                valid_q[s] <= '0;
        end else if (upd_valid_i) begin
            valid_q[u_idx][wr_way] <= 1'b1;
        end
    end

    assign lookup_hit_o = f_hit;
    assign pred_taken_o = f_hit && hist_taken(f_entry.hist);
    assign next_pc_o    = pred_taken_o ? {f_entry.target, 2'b00}
                                       : fetch_pc_i + ADDR_W'(4);

endmodule

// File: rtl/btb_checks.sv
module btb_checks
    import btb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  fetch_pc,
    input logic               lookup_hit,
    input logic               pred_taken,
    input logic [ADDR_W-1:0]  next_pc,
    input logic               upd_valid,
    input logic [ADDR_W-1:0]  upd_pc,
    input logic               upd_taken,
    input logic [ADDR_W-1:0]  upd_target,
    input logic [WAYS-1:0]    hit_vec
);

    p_seq_on_miss_r1: assert property (@(posedge clk) disable iff (rst)
        !lookup_hit |-> (!pred_taken && next_pc == fetch_pc + ADDR_W'(4)));

    p_single_way_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    p_taken_needs_hit_r3: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> lookup_hit);

    // R5, R6: a taken update leaves its entry present with the new target
    p_taken_write_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken) |=>
            (fetch_pc[ADDR_W-1:2] != $past(upd_pc[ADDR_W-1:2])) ||
            (lookup_hit && (!pred_taken ||
                next_pc == {$past(upd_target[ADDR_W-1:2]), 2'b00})));

    p_empty_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lookup_hit);

endmodule

bind btb_top btb_checks u_checks (
    .clk        (clk),
    .rst        (rst),
    .fetch_pc   (fetch_pc_i),
    .lookup_hit (lookup_hit_o),
    .pred_taken (pred_taken_o),
    .next_pc    (next_pc_o),
    .upd_valid  (upd_valid_i),
    .upd_pc     (upd_pc_i),
    .upd_taken  (upd_taken_i),
    .upd_target (upd_target_i),
    .hit_vec    (f_hit_vec)
);

// File: tb/btb_top_test.sv
module btb_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic        lookup_hit, pred_taken;
    logic [31:0] next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    btb_top uut (
        .clk          (clk),
        .rst          (rst),
        .fetch_pc_i   (fetch_pc),
        .lookup_hit_o (lookup_hit),
        .pred_taken_o (pred_taken),
        .next_pc_o    (next_pc),
        .upd_valid_i  (upd_valid),
        .upd_pc_i     (upd_pc),
        .upd_taken_i  (upd_taken),
        .upd_target_i (upd_target)
    );

    // reference model, written from the requirements
    bit        m_val [128][4];
    bit [22:0] m_tag [128][4];
    bit [1:0]  m_cnt [128][4];
    bit [29:0] m_tgt [128][4];
    bit [2:0]  m_tree[128];

    typedef struct {
        bit          hit;
        bit          tk;
        logic [31:0] npc;
        string       req;
    } exp_t;

    exp_t sb[$];

    function automatic logic [31:0] mk(input int tag, input int idx);
        return {23'(tag), 7'(idx), 2'b00};
    endfunction

    function automatic void model_clear();
        for (int s = 0; s < 128; s++) begin
            m_tree[s] = '0;
            for (int w = 0; w < 4; w++) m_val[s][w] = 1'b0;
        end
    endfunction

    function automatic int model_find(input logic [31:0] a);
        int s = int'(a[8:2]);
        for (int w = 0; w < 4; w++)
            if (m_val[s][w] && m_tag[s][w] == a[31:9]) return w;
        return -1;
    endfunction

    function automatic void model_update(input logic [31:0] a, input bit tk,
                                         input logic [31:0] tg);
        int s = int'(a[8:2]);
        int w = model_find(a);
        bit [2:0] b = m_tree[s];
        if (w >= 0) begin
            if (tk && m_cnt[s][w] != 2'd3) m_cnt[s][w] = m_cnt[s][w] + 2'd1;
            if (!tk && m_cnt[s][w] != 2'd0) m_cnt[s][w] = m_cnt[s][w] - 2'd1;
            if (tk) m_tgt[s][w] = tg[31:2];
        end else begin
            w = -1;
            for (int k = 3; k >= 0; k--) if (!m_val[s][k]) w = k;
            if (w < 0) begin
                if (!b[0]) w = b[1] ? 1 : 0;
                else       w = b[2] ? 3 : 2;
            end
            m_val[s][w] = 1'b1;
            m_tag[s][w] = a[31:9];
            m_cnt[s][w] = tk ? 2'd2 : 2'd1;
            m_tgt[s][w] = tg[31:2];
        end
        if (w < 2) begin b[0] = 1'b1; b[1] = (w == 0); end
        else       begin b[0] = 1'b0; b[2] = (w == 2); end
        m_tree[s] = b;
    endfunction

    // driver: applies one cycle of stimulus and queues the expected lookup
    task automatic step(input logic [31:0] f, input bit uv, input logic [31:0] up,
                        input bit ut, input logic [31:0] utg, input string req);
        exp_t e;
        int   w, s;
        @(posedge clk);
        #1;
        fetch_pc   = f;
        upd_valid  = uv;
        upd_pc     = up;
        upd_taken  = ut;
        upd_target = utg;
        s = int'(f[8:2]);
        w = model_find(f);
        e.req = req;
        e.hit = (w >= 0);
        e.tk  = (w >= 0) && m_cnt[s][w][1];
        e.npc = e.tk ? {m_tgt[s][w], 2'b00} : f + 32'd4;
        sb.push_back(e);
        if (uv) model_update(up, ut, utg);
    endtask

    task automatic look(input logic [31:0] f, input string req);
        step(f, 1'b0, '0, 1'b0, '0, req);
    endtask

    task automatic upd(input logic [31:0] f, input logic [31:0] up, input bit ut,
                       input logic [31:0] utg, input string req);
        step(f, 1'b1, up, ut, utg, req);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        upd_valid = 1'b0;
        @(posedge clk);
        #1;
        rst = 1'b0;
        model_clear();
    endtask

    // monitor: compares queued expectations with the ports
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (lookup_hit !== e.hit || pred_taken !== e.tk || next_pc !== e.npc) begin
                fails++;
                $display("FAIL %s pc=%h: hit/taken/next = %b/%b/%h, expected %b/%b/%h",
                         e.req, fetch_pc, lookup_hit, pred_taken, next_pc,
                         e.hit, e.tk, e.npc);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R9, R1: empty after reset, sequential next address
        look(mk(5, 3), "R9");
        look(mk(7, 127) | 32'h3, "R1");

        // R8: install while fetching the same branch, then R4 taken target
        upd(mk(5, 3), mk(5, 3), 1'b1, 32'h0000_1000, "R8");
        look(mk(5, 3), "R4");
        look(mk(5, 3) | 32'h2, "R2");            // low bits ignored
        // R2: different tag in same set misses; R5 not-taken install
        upd(mk(6, 3), mk(6, 3), 1'b0, 32'h0000_2000, "R2");
        look(mk(6, 3), "R3");
        upd(mk(6, 3), mk(6, 3), 1'b1, 32'h0000_2223, "R8");
        look(mk(6, 3), "R6");                   // counter 2 -> taken, new target

        // R6: down-counting keeps target, taken refresh replaces it
        upd(mk(5, 3), mk(5, 3), 1'b0, 32'h0000_9990, "R6");
        look(mk(5, 3), "R6");
        upd(mk(5, 3), mk(5, 3), 1'b0, 32'h0000_9990, "R6");
        upd(mk(5, 3), mk(5, 3), 1'b0, 32'h0000_9990, "R6");  // saturate at 0
        upd(mk(5, 3), mk(5, 3), 1'b1, 32'h0000_4440, "R6");
        look(mk(5, 3), "R6");                   // counter 1, not taken
        upd(mk(5, 3), mk(5, 3), 1'b1, 32'h0000_5550, "R6");
        look(mk(5, 3), "R4");
        // R6: saturation at 3
        for (int k = 0; k < 3; k++) upd(mk(0, 0), mk(6, 3), 1'b1, 32'h0000_6660, "R1");
        upd(mk(6, 3), mk(6, 3), 1'b0, 32'h0000_0000, "R6");
        look(mk(6, 3), "R6");

        // R7: fill a set, touch one way, install a fifth branch
        for (int t = 1; t <= 4; t++)
            upd(mk(t, 10), mk(t, 10), 1'b1, 32'h0001_0000 + 32'(t * 16), "R7");
        upd(mk(1, 10), mk(1, 10), 1'b1, 32'h0002_0000, "R7");
        upd(mk(9, 10), mk(9, 10), 1'b1, 32'h0003_0000, "R7");
        for (int t = 1; t <= 4; t++) look(mk(t, 10), "R7");
        look(mk(9, 10), "R7");
        upd(mk(2, 10), mk(11, 10), 1'b0, 32'h0004_0000, "R7");
        for (int t = 1; t <= 4; t++) look(mk(t, 10), "R7");
        look(mk(9, 10), "R7");
        look(mk(11, 10), "R7");

        // mixed traffic with frequent same-set update and lookup
        for (int k = 0; k < 600; k++) begin
            logic [31:0] fa, ua;
            fa = mk(int'($urandom_range(0, 5)), int'($urandom_range(20, 22)));
            ua = mk(int'($urandom_range(0, 5)), int'($urandom_range(20, 22)));
            if ($urandom_range(0, 1) == 1) ua = fa;
            step(fa, $urandom_range(0, 2) != 0, ua, $urandom_range(0, 1) == 1,
                 {$urandom, 2'b00} | 32'($urandom_range(0, 3)), "R8");
        end

        // R9: reset drops all entries
        do_reset();
        look(mk(5, 3), "R9");
        look(mk(9, 10), "R9");
        upd(mk(9, 10), mk(9, 10), 1'b1, 32'h0000_7770, "R5");
        look(mk(9, 10), "R5");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule